// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the software-visible control and status state of a multi-channel DMA layer. A processor reaches it over a simple register bus: a 10-bit register number, a 32-bit write word with a write strobe, and a read strobe that returns a 32-bit word in the same cycle. The bank holds these registers:

- global settings, an error word and an interrupt-enable word;
- per-direction channel activate set and reset words;
- per-direction end-of-buffer and descriptor-error status words;
- a current-descriptor pointer for every transmit and receive channel;
- a buffer size for every receive channel.

The DMA engine around the bank raises status bits through single-cycle event inputs. Software clears those bits by writing ones to them.

The transmit and receive channel counts are parameters, each from 1 to 32. A count outside that range stops elaboration. Fixed registers sit at 0x180 to 0x187, with 0x183 left unmapped, and at 0x190 to 0x193. Three per-channel windows start at 0x1A0, 0x1C0 and 0x1E0. Setting the top bit of the settings register performs a soft reset of the control and status words in the same cycle as the write.

Top module: `dma_ctl_regbank`

## Requirements
- R1: After hardware reset the settings register (0x180) reads 0x0007C000. The error word (0x181), the interrupt enable (0x182), the four activate words (0x184, 0x185, 0x190, 0x191) and the four status words (0x186, 0x187, 0x192, 0x193) read zero. The per-channel windows hold no defined value until they are written.
- R2: A write to 0x180 stores the written word ANDed with 0x00FFC087.
- R3: A write to 0x180 with bit 31 set also clears the following, on the same clock edge: the error word, the interrupt enable, both activate-set words (0x184, 0x190) and all four status words. The settings register still takes the masked written value. Descriptor pointers, buffer sizes and both activate-reset words (0x185, 0x191) keep their contents.
- R4: The error word and the four status words clear each bit that is written as 1 and keep every other bit. An event that sets a bit in the same cycle as a clear or a soft reset wins, so the bit ends up set.
- R5: Event input bit i of a channel status source sets status bit 31-i of the matching status word: transmit end-of-buffer at 0x186, transmit descriptor error at 0x187, receive end-of-buffer at 0x192, receive descriptor error at 0x193. Error-event bit j sets bit j of the error word.
- R6: The interrupt enable keeps only bits 4:0 of a write. The transmit activate words keep only bits 31 down to 32-TX_CHANS, which is 31:28 with the defaults. The receive activate words keep only bits 31 down to 32-RX_CHANS, which is 31:30 with the defaults.
- R7: The descriptor pointer of transmit channel i sits at 0x1A0+i, and that of receive channel i at 0x1C0+i. Both store all 32 bits.
- R8: The buffer size of receive channel i sits at 0x1E0+i and keeps only bits 7:0. The upper bits read zero.
- R9: A register number outside the mapped set reads zero, and a write to it changes no register. This includes 0x183 and window entries at or beyond the channel count.
- R10: When the read strobe is high, the read word shows the addressed register combinationally in that cycle. When the read strobe is low, the read word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_num | input | 10 | Register number |
| wr_data | input | 32 | Write word |
| wr_en | input | 1 | Write strobe, takes effect on the rising edge |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read word, combinational |
| err_evt | input | 32 | Error events, one set bit per error bit |
| tx_eob_evt | input | TX_CHANS | Transmit end-of-buffer events, one per channel |
| tx_derr_evt | input | TX_CHANS | Transmit descriptor-error events, one per channel |
| rx_eob_evt | input | RX_CHANS | Receive end-of-buffer events, one per channel |
| rx_derr_evt | input | RX_CHANS | Receive descriptor-error events, one per channel |

## Verification
The bench runs several kinds of stimulus:
- An all-ones write to every fixed register, which shows each writable mask apart from its neighbours.
- Distinct patterns written to every window entry, which show that each channel has its own storage slot.
- Writes aimed just past each window and at the 0x183 gap, which separate a correct bound check from an off-by-one.
- Events raised in the same cycle as a clearing write and as a soft reset, which show whether set wins over clear.
- A long pseudo-random mix of reads, writes and events over the whole 0x180 to 0x1FF range, which exposes cross-talk between registers that the directed steps miss.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int MAX_CHANS = 32;
  localparam int REG_W     = 32;
  localparam int NUM_W     = 10;

  localparam logic [NUM_W-1:0] REG_CFG    = 10'h180;
  localparam logic [NUM_W-1:0] REG_ERR    = 10'h181;
  localparam logic [NUM_W-1:0] REG_IEN    = 10'h182;
  localparam logic [NUM_W-1:0] REG_TXSET  = 10'h184;
  localparam logic [NUM_W-1:0] REG_TXCLR  = 10'h185;
  localparam logic [NUM_W-1:0] REG_TXEOB  = 10'h186;
  localparam logic [NUM_W-1:0] REG_TXDERR = 10'h187;
  localparam logic [NUM_W-1:0] REG_RXSET  = 10'h190;
  localparam logic [NUM_W-1:0] REG_RXCLR  = 10'h191;
  localparam logic [NUM_W-1:0] REG_RXEOB  = 10'h192;
  localparam logic [NUM_W-1:0] REG_RXDERR = 10'h193;

  // Window bases are 32-aligned, so bits 9:5 identify the window.
  localparam logic [NUM_W-1:0] WIN_TXPTR  = 10'h1A0;
  localparam logic [NUM_W-1:0] WIN_RXPTR  = 10'h1C0;
  localparam logic [NUM_W-1:0] WIN_BSIZE  = 10'h1E0;

  localparam logic [REG_W-1:0] CFG_RST    = 32'h0007_C000;
  localparam logic [REG_W-1:0] CFG_WMASK  = 32'h00FF_C087;
  localparam logic [REG_W-1:0] IEN_WMASK  = 32'h0000_001F;
  localparam int               BSIZE_W    = 8;
  localparam int               SOFT_RST_BIT = 31;

  // Number of channel status words (tx eob, tx derr, rx eob, rx derr).
  localparam int N_CHST = 4;

  typedef struct packed {
    logic cfg;
    logic err;
    logic ien;
    logic txset;
    logic txclr;
    logic rxset;
    logic rxclr;
    logic [N_CHST-1:0] chst;   // 0 tx eob, 1 tx derr, 2 rx eob, 3 rx derr
  } fixed_sel_t;

  // Mask with the top n bits of a 32-bit word set.
  function automatic logic [REG_W-1:0] top_bits(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++)
      if (i < n) m[REG_W-1-i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
  import dmareg_pkg::*;
#(
  parameter int TX_CHANS = 4,
  parameter int RX_CHANS = 2
) (
  input  logic [NUM_W-1:0] reg_num,
  output fixed_sel_t       sel,
  output logic             txp_hit,
  output logic             rxp_hit,
  output logic             bs_hit,
  output logic [4:0]       win_idx
);

  localparam int WB = 5;

  logic [WB-1:0] low;
  logic [NUM_W-WB-1:0] high;

  assign low     = reg_num[WB-1:0];
  assign high    = reg_num[NUM_W-1:WB];
  assign win_idx = low;

  always_comb begin
    sel = '0;
    unique case (reg_num)
      REG_CFG:    sel.cfg     = 1'b1;
      REG_ERR:    sel.err     = 1'b1;
      REG_IEN:    sel.ien     = 1'b1;
      REG_TXSET:  sel.txset   = 1'b1;
      REG_TXCLR:  sel.txclr   = 1'b1;
      REG_TXEOB:  sel.chst[0] = 1'b1;
      REG_TXDERR: sel.chst[1] = 1'b1;
      REG_RXSET:  sel.rxset   = 1'b1;
      REG_RXCLR:  sel.rxclr   = 1'b1;
      REG_RXEOB:  sel.chst[2] = 1'b1;
      REG_RXDERR: sel.chst[3] = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    txp_hit = (high == WIN_TXPTR[NUM_W-1:WB]) && (int'(low) < TX_CHANS);
    rxp_hit = (high == WIN_RXPTR[NUM_W-1:WB]) && (int'(low) < RX_CHANS);
    bs_hit  = (high == WIN_BSIZE[NUM_W-1:WB]) && (int'(low) < RX_CHANS);
  end

endmodule

// File: rtl/dmareg_w1c.sv
module dmareg_w1c #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] q
);

  // Set wins over clear, so no event is lost to a racing clear.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr_vec) | set_vec) & KEEP;
  end

endmodule

// File: rtl/dmareg_chan_file.sv
module dmareg_chan_file #(
  parameter int CHANS = 4,
  parameter int DW    = 32,
  localparam int IW   = (CHANS > 1) ? $clog2(CHANS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  // Plain array without reset, so it maps onto distributed RAM.
  logic [DW-1:0] mem [CHANS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/dma_ctl_regbank.sv
module dma_ctl_regbank
  import dmareg_pkg::*;
#(
  parameter int TX_CHANS = 4,
  parameter int RX_CHANS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [9:0]          reg_num,
  input  logic [31:0]         wr_data,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [31:0]         rd_data,
  input  logic [31:0]         err_evt,
  input  logic [TX_CHANS-1:0] tx_eob_evt,
  input  logic [TX_CHANS-1:0] tx_derr_evt,
  input  logic [RX_CHANS-1:0] rx_eob_evt,
  input  logic [RX_CHANS-1:0] rx_derr_evt
);

  localparam logic [REG_W-1:0] TX_MASK = top_bits(TX_CHANS);
  localparam logic [REG_W-1:0] RX_MASK = top_bits(RX_CHANS);
  localparam int TXIW = (TX_CHANS > 1) ? $clog2(TX_CHANS) : 1;
  localparam int RXIW = (RX_CHANS > 1) ? $clog2(RX_CHANS) : 1;

  if (TX_CHANS < 1 || TX_CHANS > MAX_CHANS) begin : g_bad_tx
    $error("dma_ctl_regbank: TX_CHANS must lie in 1..32");
  end
  if (RX_CHANS < 1 || RX_CHANS > MAX_CHANS) begin : g_bad_rx
    $error("dma_ctl_regbank: RX_CHANS must lie in 1..32");
  end

  // ---------------- decode ----------------
  fixed_sel_t sel, wsel;
  logic       txp_hit, rxp_hit, bs_hit;
  logic [4:0] win_idx;

  dmareg_decode #(.TX_CHANS(TX_CHANS), .RX_CHANS(RX_CHANS)) u_dec (
    .reg_num (reg_num),
    .sel     (sel),
    .txp_hit (txp_hit),
    .rxp_hit (rxp_hit),
    .bs_hit  (bs_hit),
    .win_idx (win_idx)
  );

  assign wsel = wr_en ? sel : '0;

  logic soft_rst;
  assign soft_rst = wsel.cfg & wr_data[SOFT_RST_BIT];

  // ---------------- plain control words ----------------
  logic [REG_W-1:0] cfg_q, ier_q, txset_q, txclr_q, rxset_q, rxclr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= CFG_RST;
      ier_q   <= '0;
      txset_q <= '0;
      txclr_q <= '0;
      rxset_q <= '0;
      rxclr_q <= '0;
    end else begin
      if (soft_rst) begin
        ier_q   <= '0;
        txset_q <= '0;
        rxset_q <= '0;
      end
      if (wsel.cfg)   cfg_q   <= wr_data & CFG_WMASK;
      if (wsel.ien)   ier_q   <= wr_data & IEN_WMASK;
      if (wsel.txset) txset_q <= wr_data & TX_MASK;
      if (wsel.txclr) txclr_q <= wr_data & TX_MASK;
      if (wsel.rxset) rxset_q <= wr_data & RX_MASK;
      if (wsel.rxclr) rxclr_q <= wr_data & RX_MASK;
    end
  end

  // ---------------- error word ----------------
  logic [REG_W-1:0] esr_q, esr_clr;

  assign esr_clr = soft_rst ? '1 : (wsel.err ? wr_data : '0);

  dmareg_w1c #(.W(REG_W), .KEEP('1)) u_err (
    .clk     (clk),
    .rst     (rst),
    .clr_vec (esr_clr),
    .set_vec (err_evt),
    .q       (esr_q)
  );

  // ---------------- channel status words ----------------
  logic [REG_W-1:0] chst_q   [N_CHST];
  logic [REG_W-1:0] chst_set [N_CHST];
  logic [REG_W-1:0] chst_clr [N_CHST];

  // Channel i lands on bit 31-i.
  always_comb begin
    for (int k = 0; k < N_CHST; k++) chst_set[k] = '0;
    for (int i = 0; i < TX_CHANS; i++) begin
      chst_set[0][REG_W-1-i] = tx_eob_evt[i];
      chst_set[1][REG_W-1-i] = tx_derr_evt[i];
    end
    for (int i = 0; i < RX_CHANS; i++) begin
      chst_set[2][REG_W-1-i] = rx_eob_evt[i];
      chst_set[3][REG_W-1-i] = rx_derr_evt[i];
    end
  end

  for (genvar k = 0; k < N_CHST; k++) begin : g_chst
    localparam logic [REG_W-1:0] KMASK = (k < 2) ? TX_MASK : RX_MASK;

    assign chst_clr[k] = soft_rst ? '1 : (wsel.chst[k] ? wr_data : '0);

    dmareg_w1c #(.W(REG_W), .KEEP(KMASK)) u_st (
      .clk     (clk),
      .rst     (rst),
      .clr_vec (chst_clr[k]),
      .set_vec (chst_set[k]),
      .q       (chst_q[k])
    );
  end

  // ---------------- per-channel files ----------------
  logic [REG_W-1:0]   txp_rd, rxp_rd;
  logic [BSIZE_W-1:0] bs_rd;

  dmareg_chan_file #(.CHANS(TX_CHANS), .DW(REG_W)) u_txp (
    .clk   (clk),
    .we    (wr_en & txp_hit),
    .widx  (win_idx[TXIW-1:0]),
    .wdata (wr_data),
    .ridx  (win_idx[TXIW-1:0]),
    .rdata (txp_rd)
  );

  dmareg_chan_file #(.CHANS(RX_CHANS), .DW(REG_W)) u_rxp (
    .clk   (clk),
    .we    (wr_en & rxp_hit),
    .widx  (win_idx[RXIW-1:0]),
    .wdata (wr_data),
    .ridx  (win_idx[RXIW-1:0]),
    .rdata (rxp_rd)
  );

  dmareg_chan_file #(.CHANS(RX_CHANS), .DW(BSIZE_W)) u_bs (
    .clk   (clk),
    .we    (wr_en & bs_hit),
    .widx  (win_idx[RXIW-1:0]),
    .wdata (wr_data[BSIZE_W-1:0]),
    .ridx  (win_idx[RXIW-1:0]),
    .rdata (bs_rd)
  );

  // ---------------- read path ----------------
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (sel.cfg)     rd_mux = cfg_q;
    if (sel.err)     rd_mux = esr_q;
    if (sel.ien)     rd_mux = ier_q;
    if (sel.txset)   rd_mux = txset_q;
    if (sel.txclr)   rd_mux = txclr_q;
    if (sel.rxset)   rd_mux = rxset_q;
    if (sel.rxclr)   rd_mux = rxclr_q;
    for (int k = 0; k < N_CHST; k++)
      if (sel.chst[k]) rd_mux = chst_q[k];
    if (txp_hit)     rd_mux = txp_rd;
    if (rxp_hit)     rd_mux = rxp_rd;
    if (bs_hit)      rd_mux = {{(REG_W-BSIZE_W){1'b0}}, bs_rd};
  end

  assign rd_data = rd_en ? rd_mux : '0;

endmodule

// File: rtl/dmareg_checker.sv
module dmareg_checker
  import dmareg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [9:0]  reg_num,
  input logic [31:0] wr_data,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [31:0] esr_evt,
  input logic [31:0] cfg_q,
  input logic [31:0] esr_q,
  input logic [31:0] ier_q
);

  AST_CFG_MASKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_num == REG_CFG) |=> (cfg_q == ($past(wr_data) & CFG_WMASK))); // R2

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_num == REG_CFG && wr_data[31]) |=> (ier_q == '0 && esr_q == $past(esr_evt))); // R3

  AST_ERR_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_num == REG_ERR) |=> (esr_q == (($past(esr_q) & ~$past(wr_data)) | $past(esr_evt)))); // R4

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && (reg_num == REG_ERR || reg_num == REG_CFG)) && esr_evt == '0) |=> $stable(esr_q)); // R4

  AST_IEN_LOW5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_num == REG_IEN) |=> (ier_q == {27'b0, $past(wr_data[4:0])})); // R6

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_num == 10'h183) |-> (rd_data == '0)); // R9

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_num == REG_CFG) |-> (rd_data == cfg_q)); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |-> (rd_data == '0)); // R10

endmodule

bind dma_ctl_regbank dmareg_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .reg_num (reg_num),
  .wr_data (wr_data),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .esr_evt (err_evt),
  .cfg_q   (cfg_q),
  .esr_q   (esr_q),
  .ier_q   (ier_q)
);

// File: tb/dma_ctl_regbank_bench.sv
`timescale 1ns/1ps
module dma_ctl_regbank_bench;

  localparam int TXN = 4;
  localparam int RXN = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [9:0]     reg_num = '0;
  logic [31:0]    wr_data = '0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [31:0]    rd_data;
  logic [31:0]    err_evt = '0;
  logic [TXN-1:0] tx_eob_evt = '0, tx_derr_evt = '0;
  logic [RXN-1:0] rx_eob_evt = '0, rx_derr_evt = '0;

  always #2 clk = ~clk;

  dma_ctl_regbank #(.TX_CHANS(TXN), .RX_CHANS(RXN)) u_dma_ctl_regbank (
    .clk, .rst, .reg_num, .wr_data, .wr_en, .rd_en, .rd_data,
    .err_evt, .tx_eob_evt, .tx_derr_evt, .rx_eob_evt, .rx_derr_evt
  );

  int checks = 0;
  int errors = 0;

  // ---------------- reference model ----------------
  logic [31:0] m_cfg, m_esr, m_ier, m_txset, m_txclr, m_rxset, m_rxclr;
  logic [31:0] m_st [4];
  logic [31:0] m_txp [TXN];
  logic [31:0] m_rxp [RXN];
  logic [31:0] m_bs  [RXN];

  function automatic logic [31:0] topmask(int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[31-i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] model_read(int n);
    case (n)
      'h180: return m_cfg;
      'h181: return m_esr;
      'h182: return m_ier;
      'h184: return m_txset;
      'h185: return m_txclr;
      'h186: return m_st[0];
      'h187: return m_st[1];
      'h190: return m_rxset;
      'h191: return m_rxclr;
      'h192: return m_st[2];
      'h193: return m_st[3];
      default: ;
    endcase
    if (n >= 'h1A0 && n < 'h1A0 + TXN) return m_txp[n - 'h1A0];
    if (n >= 'h1C0 && n < 'h1C0 + RXN) return m_rxp[n - 'h1C0];
    if (n >= 'h1E0 && n < 'h1E0 + RXN) return m_bs[n - 'h1E0];
    return 32'h0;
  endfunction

  task automatic model_reset();
    m_cfg = 32'h0007_C000;
    m_esr = 0; m_ier = 0; m_txset = 0; m_txclr = 0; m_rxset = 0; m_rxclr = 0;
    for (int k = 0; k < 4; k++) m_st[k] = 0;
  endtask

  task automatic model_step(int n, logic [31:0] d, bit we);
    if (we && n == 'h180 && d[31]) begin
      m_esr = 0; m_ier = 0; m_txset = 0; m_rxset = 0;
      for (int k = 0; k < 4; k++) m_st[k] = 0;
    end
    if (we) begin
      case (n)
        'h180: m_cfg   = d & 32'h00FF_C087;
        'h181: m_esr   = m_esr & ~d;
        'h182: m_ier   = d & 32'h1F;
        'h184: m_txset = d & topmask(TXN);
        'h185: m_txclr = d & topmask(TXN);
        'h186: m_st[0] = m_st[0] & ~d;
        'h187: m_st[1] = m_st[1] & ~d;
        'h190: m_rxset = d & topmask(RXN);
        'h191: m_rxclr = d & topmask(RXN);
        'h192: m_st[2] = m_st[2] & ~d;
        'h193: m_st[3] = m_st[3] & ~d;
        default: ;
      endcase
      if (n >= 'h1A0 && n < 'h1A0 + TXN) m_txp[n - 'h1A0] = d;
      if (n >= 'h1C0 && n < 'h1C0 + RXN) m_rxp[n - 'h1C0] = d;
      if (n >= 'h1E0 && n < 'h1E0 + RXN) m_bs[n - 'h1E0]  = d & 32'hFF;
    end
    m_esr = m_esr | err_evt;
    for (int i = 0; i < TXN; i++) begin
      if (tx_eob_evt[i])  m_st[0][31-i] = 1'b1;
      if (tx_derr_evt[i]) m_st[1][31-i] = 1'b1;
    end
    for (int i = 0; i < RXN; i++) begin
      if (rx_eob_evt[i])  m_st[2][31-i] = 1'b1;
      if (rx_derr_evt[i]) m_st[3][31-i] = 1'b1;
    end
  endtask

  // ---------------- checking cycle ----------------
  task automatic check(input string tag, int n, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s reg 0x%03h: got 0x%08h expected 0x%08h", tag, n, got, exp);
    end
  endtask

  // Drive one cycle; compare the read word before the edge, then step the model.
  task automatic cyc(int n, logic [31:0] d, bit we, bit re, string tag);
    reg_num = 10'(n); wr_data = d; wr_en = we; rd_en = re;
    #1;
    check(tag, n, rd_data, re ? model_read(n) : 32'h0);
    @(posedge clk);
    model_step(n, d, we);
    @(negedge clk);
    err_evt = '0; tx_eob_evt = '0; tx_derr_evt = '0; rx_eob_evt = '0; rx_derr_evt = '0;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(int n, logic [31:0] d, string tag); cyc(n, d, 1'b1, 1'b0, tag); endtask
  task automatic rd(int n, string tag);                 cyc(n, 32'h0, 1'b0, 1'b1, tag); endtask

  function automatic string reqtag(int n);
    if (n == 'h180) return "R2";
    if (n == 'h181 || n == 'h186 || n == 'h187 || (n >= 'h192 && n <= 'h193)) return "R4";
    if (n == 'h182 || n == 'h184 || n == 'h185 || n == 'h190 || n == 'h191) return "R6";
    if ((n >= 'h1A0 && n < 'h1A0 + TXN) || (n >= 'h1C0 && n < 'h1C0 + RXN)) return "R7";
    if (n >= 'h1E0 && n < 'h1E0 + RXN) return "R8";
    return "R9";
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  int fixed_regs [11] = '{'h180, 'h181, 'h182, 'h184, 'h185, 'h186, 'h187,
                          'h190, 'h191, 'h192, 'h193};
  logic [31:0] x;

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    foreach (fixed_regs[i]) rd(fixed_regs[i], "R1");

    // R10: idle strobe returns zero
    cyc('h180, 32'h0, 1'b0, 1'b0, "R10");

    // R2: settings mask (bit 31 clear)
    wr('h180, 32'h7FFF_FFFF, "R2");
    rd('h180, "R2");

    // R6: field masks
    wr('h182, 32'hFFFF_FFFF, "R6"); rd('h182, "R6");
    wr('h184, 32'hFFFF_FFFF, "R6"); rd('h184, "R6");
    wr('h185, 32'hFFFF_FFFF, "R6"); rd('h185, "R6");
    wr('h190, 32'hFFFF_FFFF, "R6"); rd('h190, "R6");
    wr('h191, 32'hFFFF_FFFF, "R6"); rd('h191, "R6");

    // R7, R8: windows filled with distinct patterns
    for (int i = 0; i < TXN; i++) wr('h1A0 + i, 32'hA000_0000 + 32'(i * 'h1111), "R7");
    for (int i = 0; i < RXN; i++) wr('h1C0 + i, 32'h5C00_0000 + 32'(i * 'h2222), "R7");
    for (int i = 0; i < RXN; i++) wr('h1E0 + i, 32'h1234_5670 + 32'(i), "R8");
    for (int i = 0; i < TXN; i++) rd('h1A0 + i, "R7");
    for (int i = 0; i < RXN; i++) rd('h1C0 + i, "R7");
    for (int i = 0; i < RXN; i++) rd('h1E0 + i, "R8");

    // R9: unmapped numbers
    wr('h1A0 + TXN, 32'hDEAD_BEEF, "R9"); rd('h1A0 + TXN, "R9"); rd('h1A0 + TXN - 1, "R9");
    wr('h1C0 + RXN, 32'hDEAD_BEEF, "R9"); rd('h1C0 + RXN, "R9"); rd('h1C0 + RXN - 1, "R9");
    wr('h1E0 + RXN, 32'hDEAD_BEEF, "R9"); rd('h1E0 + RXN, "R9"); rd('h1E0 + RXN - 1, "R9");
    wr('h183, 32'hFFFF_FFFF, "R9"); rd('h183, "R9"); rd('h182, "R9");
    wr('h188, 32'hFFFF_FFFF, "R9"); rd('h188, "R9"); rd('h000, "R9");

    // R5: event bit positions
    err_evt = 32'hA5A5_0F0F; tx_eob_evt = 4'b1010; tx_derr_evt = 4'b0001;
    rx_eob_evt = 2'b10; rx_derr_evt = 2'b01;
    cyc('h180, 32'h0, 1'b0, 1'b0, "R5");
    rd('h181, "R5"); rd('h186, "R5"); rd('h187, "R5"); rd('h192, "R5"); rd('h193, "R5");

    // R4: write-one-to-clear and set-wins
    wr('h181, 32'h0000_FFFF, "R4"); rd('h181, "R4");
    wr('h186, 32'h4000_0000, "R4"); rd('h186, "R4");
    err_evt = 32'h0000_0001;
    wr('h181, 32'h0000_0001, "R4"); rd('h181, "R4");

    // R3: soft reset with a racing event
    tx_eob_evt = 4'b0100;
    wr('h180, 32'h8000_0001, "R3");
    foreach (fixed_regs[i]) rd(fixed_regs[i], "R3");
    for (int i = 0; i < TXN; i++) rd('h1A0 + i, "R3");
    for (int i = 0; i < RXN; i++) rd('h1E0 + i, "R3");

    // Pseudo-random sweep over the whole register range
    x = 32'h1357_9BDF;
    for (int k = 0; k < 1500; k++) begin
      int n;
      logic [31:0] d;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      n = 'h180 + int'(x[6:0]);
      d = {x[15:0], x[31:16]} ^ 32'h6A09_E667;
      if (x[10:8] == 3'd0) err_evt = d;
      if (x[12:11] == 2'd0) begin
        tx_eob_evt = x[20:17]; tx_derr_evt = x[24:21]; rx_eob_evt = x[26:25]; rx_derr_evt = x[28:27];
      end
      cyc(n, d, x[7], x[29] | ~x[7], reqtag(n));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule